// File: doc/BRIEF.md
# On-Demand K-Best Candidate Selector

This block picks the K best child nodes of one tree level in a breadth-first MIMO detector, and it does so without expanding every child of every parent. The parents of the level arrive as one parallel word. Each slot holds the partial distance of a parent's best child and that parent's index, and the slots are already in ascending order of distance. The selector keeps these entries in an ordered register bank. It hands out the smallest entry as the next survivor and then asks an outside child-generation unit for the next-best sibling of that parent. When the answer comes back, the announced entry is dropped and the sibling is inserted into the bank at its sorted position, all in one clock. This emit-and-replace loop runs until K candidates have left the block. A typical setting is eight parents, one per child of a 4x4 64-QAM level, and K=10.

Three stream interfaces use valid/ready:
- **Load:** accepted only while the selector is idle.
- **Candidate output:** the consumer may hold `cand_ready` low for any time. The candidate then stays on the outputs unchanged.
- **Sibling request and response:** a request names a parent and stays presented, unchanged, until `req_ready`. The response is taken while `rsp_ready` is high. A response flagged as having no sibling puts the largest distance in place of the entry, so that entry sinks to the end of the bank.

A one-cycle completion pulse follows the K-th accepted candidate.

Top module: `kb_select_top`

## Requirements
- R1: After reset, `ld_ready` is 1 and `cand_valid`, `req_valid`, `rsp_ready` and `done` are 0.
- R2: A load is taken on a clock edge where `ld_valid` and `ld_ready` are both high. Slot s of the load sits at bits [s*DW +: DW] of `ld_dist` and [s*IW +: IW] of `ld_pidx`. The slots must be non-decreasing in distance from slot 0 upward.
- R3: Every candidate presented carries the smallest distance held in the working set, together with that entry's parent index.
- R4: After each accepted candidate except the K-th, exactly one sibling request is issued, and `req_pidx` equals the parent index of the candidate just accepted.
- R5: A returned sibling distance is inserted behind all entries of equal or smaller distance. Among equal distances, the entry in the lower slot leaves first, and the replacement keeps the announced parent's index.
- R6: A response with `rsp_none`=1 sets the replacement distance to 4095 (all ones) whatever `rsp_dist` holds. That entry lands in the last slot.
- R7: Exactly K candidates are accepted per load. `done` is high for one cycle, in the cycle after the K-th candidate handshake, and `ld_ready` is 1 in that same cycle.
- R8: While `cand_valid` is high and `cand_ready` low, the candidate stays valid and unchanged. The same holds for a pending request while `req_ready` is low.
- R9: No sibling request follows the K-th candidate.
- R10: `ld_valid` asserted while a level is being processed is ignored: `ld_ready` stays 0 and the candidate sequence is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Level load offered |
| ld_ready | output | 1 | Selector idle, load accepted |
| ld_dist | input | NPAR*DW | First-child distances, ascending by slot |
| ld_pidx | input | NPAR*IW | Parent index per slot |
| cand_valid | output | 1 | Candidate presented |
| cand_ready | input | 1 | Consumer takes candidate |
| cand_dist | output | DW | Candidate distance |
| cand_pidx | output | IW | Candidate parent index |
| req_valid | output | 1 | Sibling request presented |
| req_ready | input | 1 | Child unit takes request |
| req_pidx | output | IW | Parent whose next sibling is wanted |
| rsp_valid | input | 1 | Sibling response offered |
| rsp_ready | output | 1 | Selector waits for a response |
| rsp_dist | input | DW | Next-sibling distance |
| rsp_none | input | 1 | Parent has no remaining sibling |
| done | output | 1 | One-cycle pulse after the K-th candidate |

## Verification
Several properties are checked on every cycle:
- the working bank stays in ascending order;
- a load is only accepted in order;
- an exhausted entry lands in the tail slot;
- only one handshake phase is open at a time;
- the output and request streams hold still under back-pressure;
- a request only follows an accepted candidate;
- the completion pulse lasts a single cycle.

Other behaviours can only be shown by the bench's scenarios. These are the exact emitted sequence against a lazily expanded reference, tie ordering between equal distances, the values emitted after parents run out of children, and the fact that loads offered mid-level leave the sequence untouched.

// File: rtl/kb_pkg.sv
package kb_pkg;
  // Phase of the emit/replace loop; exactly one stream is open per phase.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } kb_state_e;
endpackage

// File: rtl/kb_slot_bank.sv
module kb_slot_bank #(
  parameter int N  = 8,
  parameter int DW = 12,
  parameter int IW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [N*DW-1:0] load_dist,
  input  logic [N*IW-1:0] load_pidx,
  input  logic            ins_en,
  input  logic [DW-1:0]   ins_dist,
  input  logic [IW-1:0]   ins_pidx,
  output logic [DW-1:0]   head_dist,
  output logic [IW-1:0]   head_pidx
);
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  logic [DW-1:0] d_q [N];
  logic [IW-1:0] p_q [N];
  logic [DW-1:0] d_nx [N];
  logic [IW-1:0] p_nx [N];
  // gt[j]: the entry that will sit in slot j after the head leaves is
  // strictly larger than the incoming value. Slot N-1 has no such entry.
  logic [N-1:0]  gt;
  logic [N-1:0]  le_prev;

  genvar j;
  generate
    for (j = 0; j < N; j++) begin : g_cmp
      if (j < N-1) begin : g_real
        assign gt[j] = d_q[j+1] > ins_dist;
      end else begin : g_virt
        assign gt[j] = 1'b1;
      end
      if (j == 0) begin : g_first
        assign le_prev[j] = 1'b1;
      end else begin : g_rest
        assign le_prev[j] = !gt[j-1];
      end
    end

    // Each slot: take the right neighbour (head removal shifts left),
    // take the new value, or keep its own content.
    for (j = 0; j < N; j++) begin : g_slot
      if (j < N-1) begin : g_mid
        always_comb begin
          if (!gt[j]) begin
            d_nx[j] = d_q[j+1];
            p_nx[j] = p_q[j+1];
          end else if (le_prev[j]) begin
            d_nx[j] = ins_dist;
            p_nx[j] = ins_pidx;
          end else begin
            d_nx[j] = d_q[j];
            p_nx[j] = p_q[j];
          end
        end
      end else begin : g_tail
        always_comb begin
          if (le_prev[j]) begin
            d_nx[j] = ins_dist;
            p_nx[j] = ins_pidx;
          end else begin
            d_nx[j] = d_q[j];
            p_nx[j] = p_q[j];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q[j] <= DMAX;
          p_q[j] <= '0;
        end else if (load_en) begin
          d_q[j] <= load_dist[j*DW +: DW];
          p_q[j] <= load_pidx[j*IW +: IW];
        end else if (ins_en) begin
          d_q[j] <= d_nx[j];
          p_q[j] <= p_nx[j];
        end
      end
    end
  endgenerate

  assign head_dist = d_q[0];
  assign head_pidx = p_q[0];

  // Ordering of the offered load, checked at acceptance.
  logic load_sorted;
  always_comb begin
    load_sorted = 1'b1;
    for (int s = 0; s < N-1; s++) begin
      if (load_dist[s*DW +: DW] > load_dist[(s+1)*DW +: DW]) load_sorted = 1'b0;
    end
  end

  a_r2_load_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> load_sorted);

  generate
    for (j = 0; j < N-1; j++) begin : g_ord
      a_r5_bank_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        d_q[j] <= d_q[j+1]);
    end
  endgenerate

  a_r6_exhausted_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !load_en && ins_dist == DMAX) |=>
      (d_q[N-1] == DMAX && p_q[N-1] == $past(ins_pidx)));
endmodule

// File: rtl/kb_step_ctrl.sv
module kb_step_ctrl
  import kb_pkg::*;
#(
  parameter int K = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_valid,
  output logic ld_ready,
  output logic cand_valid,
  input  logic cand_ready,
  output logic req_valid,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic rsp_ready,
  output logic load_en,
  output logic ins_en,
  output logic done
);
  localparam int CW = (K > 2) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST = CW'(K-1);

  kb_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic take, req_go, last_out;

  assign ld_ready   = (st_q == ST_IDLE);
  assign cand_valid = (st_q == ST_EMIT);
  assign req_valid  = (st_q == ST_REQ);
  assign rsp_ready  = (st_q == ST_WAIT);
  assign load_en    = ld_valid && ld_ready;
  assign take       = cand_valid && cand_ready;
  assign req_go     = req_valid && req_ready;
  assign ins_en     = rsp_valid && rsp_ready;
  assign last_out   = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= take && last_out;
      unique case (st_q)
        ST_IDLE: if (load_en) begin
          st_q  <= ST_EMIT;
          cnt_q <= '0;
        end
        ST_EMIT: if (take) begin
          if (last_out) st_q <= ST_IDLE;
          else begin
            st_q  <= ST_REQ;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_REQ:  if (req_go) st_q <= ST_WAIT;
        ST_WAIT: if (ins_en) st_q <= ST_EMIT;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r4_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ld_ready, cand_valid, req_valid, rsp_ready}));
  a_r4_req_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(take));
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ld_ready);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r9_no_req_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

// File: rtl/kb_select_top.sv
module kb_select_top #(
  parameter int NPAR = 8,
  parameter int DW   = 12,
  parameter int K    = 10,
  parameter int IW   = (NPAR > 1) ? $clog2(NPAR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [NPAR*DW-1:0] ld_dist,
  input  logic [NPAR*IW-1:0] ld_pidx,
  output logic               cand_valid,
  input  logic               cand_ready,
  output logic [DW-1:0]      cand_dist,
  output logic [IW-1:0]      cand_pidx,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [IW-1:0]      req_pidx,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [DW-1:0]      rsp_dist,
  input  logic               rsp_none,
  output logic               done
);
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  logic          load_en, ins_en;
  logic [DW-1:0] head_dist, repl_dist;
  logic [IW-1:0] head_pidx;

  // A parent with no remaining sibling gets the largest distance.
  assign repl_dist = rsp_none ? DMAX : rsp_dist;

  kb_step_ctrl #(.K(K)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_ready   (ld_ready),
    .cand_valid (cand_valid),
    .cand_ready (cand_ready),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .load_en    (load_en),
    .ins_en     (ins_en),
    .done       (done)
  );

  kb_slot_bank #(.N(NPAR), .DW(DW), .IW(IW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_dist (ld_dist),
    .load_pidx (ld_pidx),
    .ins_en    (ins_en),
    .ins_dist  (repl_dist),
    .ins_pidx  (head_pidx),
    .head_dist (head_dist),
    .head_pidx (head_pidx)
  );

  // The head stays put until the response is inserted, so it names
  // the parent both for the candidate and for its sibling request.
  assign cand_dist = head_dist;
  assign cand_pidx = head_pidx;
  assign req_pidx  = head_pidx;

  a_r8_cand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_ready) |=>
      (cand_valid && $stable(cand_dist) && $stable(cand_pidx)));
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_pidx)));
  a_r10_busy_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid || req_valid || rsp_ready) |-> !ld_ready);
endmodule

// File: tb/kb_select_top_tb_top.sv
module kb_select_top_tb_top;
  localparam int NP = 8, DW = 12, K = 10, IW = 3, MAXC = 8;
  localparam int DMAX = 4095;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, cand_ready = 1'b0, req_ready = 1'b0;
  logic rsp_valid = 1'b0, rsp_none = 1'b0;
  logic [NP*DW-1:0] ld_dist = '0;
  logic [NP*IW-1:0] ld_pidx = '0;
  logic [DW-1:0] rsp_dist = '0;
  logic ld_ready, cand_valid, req_valid, rsp_ready, done;
  logic [DW-1:0] cand_dist;
  logic [IW-1:0] cand_pidx, req_pidx;

  always #10 clk = ~clk;

  kb_select_top #(.NPAR(NP), .DW(DW), .K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_dist(ld_dist), .ld_pidx(ld_pidx), .cand_valid(cand_valid),
    .cand_ready(cand_ready), .cand_dist(cand_dist), .cand_pidx(cand_pidx),
    .req_valid(req_valid), .req_ready(req_ready), .req_pidx(req_pidx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_dist(rsp_dist),
    .rsp_none(rsp_none), .done(done));

  int n_chk = 0, n_bad = 0;
  int ch_d [NP][MAXC];
  int ch_n [NP];
  int gen_ptr [NP];
  int ord_d [NP], ord_p [NP];
  int exp_d [K], exp_p [K];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind 0: random, 1: all-equal ties, 2: one child each, 3: few children
  task automatic setup_case(input int kind);
    for (int p = 0; p < NP; p++) begin
      case (kind)
        1: ch_n[p] = 3;
        2: ch_n[p] = 1;
        3: ch_n[p] = 1 + int'($urandom % 2);
        default: ch_n[p] = 2 + int'($urandom % 7);
      endcase
      for (int c = 0; c < MAXC; c++) begin
        if (kind == 1) ch_d[p][c] = (c < 2) ? 500 : 600;
        else if (c == 0) ch_d[p][c] = int'($urandom % 1500);
        else begin
          ch_d[p][c] = ch_d[p][c-1] + int'($urandom % 300);
          if (ch_d[p][c] > 4000) ch_d[p][c] = 4000;
        end
      end
    end
    // stable ascending order of parents by first-child distance
    for (int s = 0; s < NP; s++) begin
      ord_p[s] = s;
      ord_d[s] = ch_d[s][0];
    end
    for (int i = 1; i < NP; i++) begin
      for (int j = i; j > 0; j--) begin
        if (ord_d[j-1] > ord_d[j]) begin
          int td, tp;
          td = ord_d[j]; tp = ord_p[j];
          ord_d[j] = ord_d[j-1]; ord_p[j] = ord_p[j-1];
          ord_d[j-1] = td; ord_p[j-1] = tp;
        end
      end
    end
  endtask

  // Reference: lazy expansion, new entries placed behind equal ones.
  task automatic build_model();
    int wd [NP], wp [NP], mptr [NP];
    for (int s = 0; s < NP; s++) begin
      wd[s] = ord_d[s]; wp[s] = ord_p[s]; mptr[s] = 1;
    end
    for (int k = 0; k < K; k++) begin
      exp_d[k] = wd[0]; exp_p[k] = wp[0];
      if (k < K-1) begin
        int p, v, pos;
        p = wp[0];
        if (mptr[p] < ch_n[p]) begin v = ch_d[p][mptr[p]]; mptr[p]++; end
        else v = DMAX;
        for (int s = 0; s < NP-1; s++) begin wd[s] = wd[s+1]; wp[s] = wp[s+1]; end
        pos = NP-1;
        for (int s = 0; s < NP-1; s++) if (wd[s] > v && pos == NP-1) pos = s;
        for (int s = NP-1; s > pos; s--) begin wd[s] = wd[s-1]; wp[s] = wp[s-1]; end
        wd[pos] = v; wp[pos] = p;
      end
    end
  endtask

  task automatic run_case(input int kind, input int bp, input string tag);
    int got = 0, cyc = 0, pend_p = 0, delay = 0, prev_d = 0;
    bit pend = 0, fin = 0, last_taken = 0, prev_stall = 0, req_seen = 0;
    setup_case(kind);
    build_model();
    for (int p = 0; p < NP; p++) gen_ptr[p] = 1;
    @(negedge clk);
    for (int s = 0; s < NP; s++) begin
      ld_dist[s*DW +: DW] = 12'(ord_d[s]);
      ld_pidx[s*IW +: IW] = 3'(ord_p[s]);
    end
    check(ld_ready == 1'b1, "R2 load ready when idle", int'(ld_ready), 1);
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    while (!fin && cyc < 3000) begin
      if (last_taken) begin
        check(done == 1'b1, "R7 done pulse", int'(done), 1);
        check(ld_ready == 1'b1, "R7 ready after last", int'(ld_ready), 1);
        check(req_valid == 1'b0, "R9 no request after last", int'(req_valid), 0);
        cand_ready = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; ld_valid = 1'b0;
        fin = 1;
      end else begin
        if (prev_stall)
          check(cand_valid && cand_dist == 12'(prev_d), "R8 candidate held",
                int'(cand_dist), prev_d);
        // R10: junk load offers while busy
        if (!ld_ready && ($urandom % 4 == 0)) begin
          ld_valid = 1'b1;
          ld_dist = {$urandom, $urandom, $urandom};
          check(ld_ready == 1'b0, "R10 load blocked while busy", int'(ld_ready), 0);
        end else ld_valid = 1'b0;
        // sibling response
        if (pend) begin
          if (delay > 0) begin delay--; rsp_valid = 1'b0; end
          else begin
            rsp_valid = 1'b1;
            if (gen_ptr[pend_p] < ch_n[pend_p]) begin
              rsp_none = 1'b0;
              rsp_dist = 12'(ch_d[pend_p][gen_ptr[pend_p]]);
            end else begin
              rsp_none = 1'b1;
              rsp_dist = 12'($urandom);
            end
            if (rsp_ready) begin
              if (gen_ptr[pend_p] < ch_n[pend_p]) gen_ptr[pend_p]++;
              pend = 0;
            end
          end
        end else rsp_valid = 1'b0;
        // candidate stream
        cand_ready = ($urandom % 100) >= bp;
        if (cand_valid && cand_ready) begin
          check(got < K, "R7 no extra candidate", got, K-1);
          if (got < K) begin
            check(int'(cand_dist) == exp_d[got], {tag, " candidate distance"},
                  int'(cand_dist), exp_d[got]);
            check(int'(cand_pidx) == exp_p[got], {tag, " candidate parent"},
                  int'(cand_pidx), exp_p[got]);
          end
          got++;
          req_seen = 0;
          if (got == K) last_taken = 1;
        end
        prev_stall = cand_valid && !cand_ready;
        prev_d = int'(cand_dist);
        // request stream
        req_ready = ($urandom % 100) >= bp;
        if (req_valid && !req_seen && got > 0) begin
          check(int'(req_pidx) == exp_p[got-1], "R4 request parent",
                int'(req_pidx), exp_p[got-1]);
          req_seen = 1;
        end
        if (req_valid && req_ready) begin
          pend = 1; pend_p = int'(req_pidx); delay = int'($urandom % 3);
        end
      end
      @(negedge clk);
      cyc++;
    end
    if (!fin) check(0, "R7 level did not complete", got, K);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ld_ready == 1'b1, "R1 reset ld_ready", int'(ld_ready), 1);
    check(cand_valid == 1'b0, "R1 reset cand_valid", int'(cand_valid), 0);
    check(req_valid == 1'b0, "R1 reset req_valid", int'(req_valid), 0);
    check(rsp_ready == 1'b0, "R1 reset rsp_ready", int'(rsp_ready), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    // directed corners
    run_case(1, 0, "R5");
    run_case(1, 50, "R5");
    run_case(2, 0, "R6");
    run_case(2, 40, "R6");
    run_case(0, 0, "R3");
    // random mix
    for (int i = 0; i < 16; i++) run_case(0, int'($urandom % 70), "R3");
    for (int i = 0; i < 4; i++) run_case(3, int'($urandom % 50), "R6");
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule